// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor with Target Buffer

This block sits beside the fetch stage of a pipelined processor and guesses, for every fetch address, whether a branch there will be taken and where it will go. It keeps a table of two-bit saturating counters and a target buffer. Both are selected by the low-order word-address bits of the program counter. The lookup is purely combinational. It returns a direction, a target-buffer hit, the stored target and the next fetch address.

When a branch resolves further down the pipeline, the resolving stage presents its address, its real outcome and its real target on the update port. In that same cycle the block flags a mispredict if the stored guess was wrong. At the next clock edge it moves the counter one step and, for a taken branch, fills or replaces the target-buffer entry. Flushing wrong-path instructions is the pipeline's job; the block only raises the flag.

Each counter is a four-state machine. The states are, from lowest to highest:
- `CTR_STRONG_NT` (00)
- `CTR_WEAK_NT` (01)
- `CTR_WEAK_T` (10)
- `CTR_STRONG_T` (11)

There are two named transitions. *step-up* is taken on a taken outcome and moves one state higher, holding at `CTR_STRONG_T`. *step-down* is taken on a not-taken outcome and moves one state lower, holding at `CTR_STRONG_NT`.

Top module: `bp_two_bit_predictor`

## Requirements
- R1: After reset, every counter is `CTR_STRONG_NT` and every target-buffer entry is invalid. Any lookup then gives pred_taken=0, pred_hit=0 and next_pc=fetch_pc+4.
- R2: Bits [7:2] of the address select one of 64 counters and one of 64 target-buffer entries. Two addresses that differ only above bit 7 share a counter. A target-buffer hit requires a valid entry whose stored tag equals address bits [31:8].
- R3: A counter steps up on a taken outcome and down on a not-taken outcome, saturating at 11 and at 00. pred_taken is the counter's upper bit, so states 10 and 11 predict taken.
- R4: From a strong state, the prediction changes only after two consecutive outcomes against it.
- R5: A resolved taken branch writes valid, tag and target into the target-buffer entry at its index. A resolved not-taken branch leaves the target buffer unchanged.
- R6: next_pc equals pred_target when pred_hit and pred_taken are both 1, and equals fetch_pc+4 otherwise.
- R7: mispredict is combinational and valid in the same cycle as upd_valid. It is 1 when the stored direction differs from upd_taken. It is also 1 when both the stored direction and upd_taken are taken but the target buffer holds no matching target for upd_pc. It is 0 whenever upd_valid is 0.
- R8: An update takes effect at the next rising clock edge. A lookup in the update cycle sees the old state, and the lookup in the following cycle sees the new state.
- R9: A taken update whose tag differs from the stored tag replaces the entry, so the earlier address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | 32 | Fetch address to look up |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| pred_hit | output | 1 | Target buffer holds an entry for fetch_pc |
| pred_target | output | 32 | Stored target for fetch_pc |
| next_pc | output | 32 | Next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_target | input | 32 | Actual target of the resolved branch |
| mispredict | output | 1 | The stored prediction for upd_pc was wrong |

## Verification
The assertions assume that the update inputs are stable around each rising edge. They also assume that fetch_pc, when compared with the previous cycle's update, is driven before the edge at which it is sampled. The bench meets both conditions by changing every input only at falling edges.

The directed scenarios do the following:
- walk one counter through every state and past both saturation limits;
- alias two addresses onto one index;
- present a lookup and an update for the same address in one cycle;
- resolve a branch whose direction is right but whose target is wrong.

Every expected value is worked out by hand from the counter rules.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_t;

    // step-up on taken, step-down on not taken, holding at both ends
    function automatic ctr_state_t ctr_step(input ctr_state_t cur, input logic taken);
        ctr_state_t nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_STRONG_NT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_state_t       rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    output ctr_state_t       wr_state
);

    localparam int DEPTH = 1 << IDX_W;

    logic [2*DEPTH-1:0] state_flat;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
            ctr_state_t state_q;
            ctr_state_t state_d;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= CTR_STRONG_NT;
                end else begin
                    state_q <= state_d;
                end
            end

            always_comb begin
                state_d = state_q;
                if (wr_en && (wr_idx == MY_IDX)) begin
                    state_d = ctr_step(state_q, wr_taken);
                end
            end

            assign state_flat[2*g +: 2] = state_q;
        end
    endgenerate

    assign rd_state = ctr_state_t'(state_flat[2*rd_idx +: 2]);
    assign wr_state = ctr_state_t'(state_flat[2*wr_idx +: 2]);

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [TAG_W-1:0]  cmp_tag,
    output logic              cmp_hit,
    output logic [ADDR_W-1:0] cmp_target,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q [DEPTH];
    logic [ADDR_W-1:0] tgt_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    assign rd_hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_target  = tgt_q[rd_idx];
    assign cmp_hit    = valid_q[cmp_idx] && (tag_q[cmp_idx] == cmp_tag);
    assign cmp_target = tgt_q[cmp_idx];

endmodule

// File: rtl/bp_two_bit_predictor.sv
module bp_two_bit_predictor
    import bp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_taken,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_target,
    output logic [ADDR_W-1:0] next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    output logic              mispredict
);

    localparam int TAG_W = ADDR_W - IDX_W - 2;

    logic [IDX_W-1:0]  fetch_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [TAG_W-1:0]  fetch_tag;
    logic [TAG_W-1:0]  upd_tag;
    ctr_state_t        look_state;
    ctr_state_t        upd_state;
    logic              cmp_hit;
    logic [ADDR_W-1:0] cmp_target;

    assign fetch_idx = fetch_pc[IDX_W+1:2];
    assign fetch_tag = fetch_pc[ADDR_W-1:IDX_W+2];
    assign upd_idx   = upd_pc[IDX_W+1:2];
    assign upd_tag   = upd_pc[ADDR_W-1:IDX_W+2];

    bp_dir_table #(
        .IDX_W(IDX_W)
    ) i_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_idx),
        .rd_state (look_state),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .wr_state (upd_state)
    );

    bp_target_buf #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) i_tbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (fetch_idx),
        .rd_tag     (fetch_tag),
        .rd_hit     (pred_hit),
        .rd_target  (pred_target),
        .cmp_idx    (upd_idx),
        .cmp_tag    (upd_tag),
        .cmp_hit    (cmp_hit),
        .cmp_target (cmp_target),
        .wr_en      (upd_valid && upd_taken),
        .wr_idx     (upd_idx),
        .wr_tag     (upd_tag),
        .wr_target  (upd_target)
    );

    // lookup outputs
    always_comb begin
        pred_taken = look_state[1];
        if (pred_hit && pred_taken) begin
            next_pc = pred_target;
        end else begin
            next_pc = fetch_pc + ADDR_W'(4);
        end
    end

    // resolve-side output
    always_comb begin
        mispredict = 1'b0;
        if (upd_valid) begin
            if (upd_state[1] != upd_taken) begin
                mispredict = 1'b1;
            end else if (upd_taken && !(cmp_hit && (cmp_target == upd_target))) begin
                mispredict = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bp_checker.sv
module bp_checker
    import bp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_taken,
    input logic              pred_hit,
    input logic [ADDR_W-1:0] pred_target,
    input logic [ADDR_W-1:0] next_pc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target,
    input logic              mispredict,
    input ctr_state_t        upd_state,
    input ctr_state_t        look_state
);

    logic [IDX_W-1:0] f_idx;
    logic [IDX_W-1:0] u_idx;

    assign f_idx = fetch_pc[IDX_W+1:2];
    assign u_idx = upd_pc[IDX_W+1:2];

    a_r1_reset_cold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pred_taken && !pred_hit));

    a_r7_quiet_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !mispredict);

    a_r7_wrong_direction: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_state[1] != upd_taken)) |-> mispredict);

    a_r3_taken_leaves_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
            ((f_idx != $past(u_idx)) || (look_state != CTR_STRONG_NT)));

    a_r3_not_taken_leaves_top: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=>
            ((f_idx != $past(u_idx)) || (look_state != CTR_STRONG_T)));

    a_r5_fill_on_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
            ((fetch_pc != $past(upd_pc)) || (pred_hit && (pred_target == $past(upd_target)))));

    a_r6_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(pred_hit && pred_taken) |-> (next_pc == fetch_pc + ADDR_W'(4)));

endmodule

bind bp_two_bit_predictor bp_checker #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_pc    (fetch_pc),
    .pred_taken  (pred_taken),
    .pred_hit    (pred_hit),
    .pred_target (pred_target),
    .next_pc     (next_pc),
    .upd_valid   (upd_valid),
    .upd_pc      (upd_pc),
    .upd_taken   (upd_taken),
    .upd_target  (upd_target),
    .mispredict  (mispredict),
    .upd_state   (upd_state),
    .look_state  (look_state)
);

// File: tb/test_bp_two_bit_predictor.sv
module test_bp_two_bit_predictor;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken;
    logic        pred_hit;
    logic [31:0] pred_target;
    logic [31:0] next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        mispredict;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [31:0] PC_A = 32'h0000_1040;
    localparam logic [31:0] PC_B = 32'h0000_0500;
    localparam logic [31:0] PC_C = 32'h0000_1140;
    localparam logic [31:0] PC_D = 32'h0000_00C0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_two_bit_predictor i_bp_two_bit_predictor (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_pc    (fetch_pc),
        .pred_taken  (pred_taken),
        .pred_hit    (pred_hit),
        .pred_target (pred_target),
        .next_pc     (next_pc),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_taken   (upd_taken),
        .upd_target  (upd_target),
        .mispredict  (mispredict)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic exp_t, input logic exp_h,
                        input logic [31:0] exp_next, input string req);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        chk({req, " pred_taken"}, 32'(pred_taken), 32'(exp_t));
        chk({req, " pred_hit"}, 32'(pred_hit), 32'(exp_h));
        chk({req, " next_pc"}, next_pc, exp_next);
    endtask

    task automatic resolve(input logic [31:0] pc, input logic taken, input logic [31:0] tgt,
                           input logic exp_mis, input string req);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_taken  = taken;
        upd_target = tgt;
        #1;
        chk({req, " mispredict"}, 32'(mispredict), 32'(exp_mis));
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic t_reset;
        look(32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104, "R1 cold lookup");
        look(PC_A, 1'b0, 1'b0, PC_A + 32'd4, "R1 cold lookup A");
        chk("R7 idle mispredict", 32'(mispredict), 32'd0);
    endtask

    task automatic t_counter_walk;
        resolve(PC_A, 1'b1, 32'h0000_2000, 1'b1, "R7 strong-nt vs taken");
        look(PC_A, 1'b0, 1'b1, PC_A + 32'd4, "R6 hit but weak-nt");
        resolve(PC_A, 1'b1, 32'h0000_2000, 1'b1, "R7 weak-nt vs taken");
        look(PC_A, 1'b1, 1'b1, 32'h0000_2000, "R6 redirect weak-t");
        resolve(PC_A, 1'b1, 32'h0000_2000, 1'b0, "R7 correct taken");
        resolve(PC_A, 1'b1, 32'h0000_2000, 1'b0, "R3 taken at top");
        look(PC_A, 1'b1, 1'b1, 32'h0000_2000, "R3 saturate high");
        resolve(PC_A, 1'b0, 32'h0, 1'b1, "R7 strong-t vs not taken");
        look(PC_A, 1'b1, 1'b1, 32'h0000_2000, "R4 one miss keeps taken");
        resolve(PC_A, 1'b0, 32'h0, 1'b1, "R4 second miss");
        look(PC_A, 1'b0, 1'b1, PC_A + 32'd4, "R5 not taken keeps buffer");
        resolve(PC_A, 1'b0, 32'h0, 1'b0, "R7 correct not taken");
        resolve(PC_A, 1'b0, 32'h0, 1'b0, "R3 not taken at floor");
        resolve(PC_A, 1'b1, 32'h0000_2000, 1'b1, "R3 taken from floor");
        look(PC_A, 1'b0, 1'b1, PC_A + 32'd4, "R3 saturate low");
    endtask

    task automatic t_alias;
        look(PC_C, 1'b0, 1'b0, PC_C + 32'd4, "R2 shared index other tag");
        resolve(PC_C, 1'b1, 32'h0000_3000, 1'b1, "R2 shared counter weak-nt");
        look(PC_C, 1'b1, 1'b1, 32'h0000_3000, "R9 new tag installed");
        look(PC_A, 1'b1, 1'b0, PC_A + 32'd4, "R9 old tag replaced");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        fetch_pc   = PC_B;
        upd_valid  = 1'b1;
        upd_pc     = PC_B;
        upd_taken  = 1'b1;
        upd_target = 32'h0000_6000;
        #1;
        chk("R8 old hit in update cycle", 32'(pred_hit), 32'd0);
        chk("R8 old direction in update cycle", 32'(pred_taken), 32'd0);
        chk("R7 same-cycle mispredict", 32'(mispredict), 32'd1);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        #1;
        chk("R8 new hit next cycle", 32'(pred_hit), 32'd1);
        chk("R8 new target next cycle", pred_target, 32'h0000_6000);
        chk("R8 weak-nt next cycle", 32'(pred_taken), 32'd0);
    endtask

    task automatic t_wrong_target;
        resolve(PC_D, 1'b1, 32'h0000_4000, 1'b1, "R7 D first taken");
        resolve(PC_D, 1'b1, 32'h0000_4000, 1'b1, "R7 D second taken");
        resolve(PC_D, 1'b1, 32'h0000_5000, 1'b1, "R7 target mismatch");
        look(PC_D, 1'b1, 1'b1, 32'h0000_5000, "R5 target rewritten");
        resolve(PC_D, 1'b1, 32'h0000_5000, 1'b0, "R7 target match");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_counter_walk();
        t_alias();
        t_same_cycle();
        t_wrong_target();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule